// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block holds the time of day and the calendar as seven packed-BCD byte registers: seconds, minutes, hours, day of week, date, month and a two-digit year. Each pulse on the one-second tick input advances seconds. Carries then ripple in the same cycle through minutes, hours, date, month and year. Day of week steps alongside the date. The date limit follows the current month, and February gains a 29th day in years divisible by four.

A write port from the host bus interface loads any one register per cycle. The hours byte carries its own mode bit (bit 6, 1 = 12-hour) and, in 12-hour mode, a PM flag in bit 5. Bit 7 of seconds is a flag bit owned by the oscillator control. It is stored and returned but never counts. Written values are assumed legal; only the bits defined as constant zero are cleared.

Top module: `bcd_rtc_chain`

## Requirements
- R1: Seconds (bits 6..0) and minutes count 0x00..0x59 in BCD on each carry-in; the step from 0x59 gives 0x00 and carries into the next field in the same cycle.
- R2: With hours bit 6 = 0, hours count 0x00..0x23, and 0x23 → 0x00 carries into date and day of week.
- R3: With hours bit 6 = 1, hours bits 4..0 run 12, 01..11 in BCD, and bit 5 is PM. 0x51 (11 AM) → 0x72 (12 PM) → 0x61 (1 PM), and 0x71 (11 PM) → 0x52 (12 AM) with a carry into date and day of week. 0x52 → 0x41.
- R4: Day of week counts 1..7 and returns to 1 on each day carry.
- R5: Date wraps to 0x01 with a carry into month after 0x31 in months 01,03,05,07,08,10,12 and after 0x30 in months 04,06,09,11.
- R6: In February the date wraps after 0x29 when the year is a leap year and after 0x28 otherwise. A year is a leap year when its units digit plus twice its tens digit is a multiple of 4.
- R7: Month wraps from 0x12 to 0x01 with a carry into year; year wraps from 0x99 to 0x00.
- R8: A write at address 0..6 (seconds, minutes, hours, day of week, date, month, year) loads the data with fixed-zero bits cleared. Minutes and hours keep bits 6..0, day of week bits 2..0, date bits 5..0, month bits 4..0; seconds and year keep all bits.
- R9: Seconds bit 7 is never changed by counting; only a write to address 0 changes it.
- R10: A write in the same cycle as an advance wins for that field. No carry leaves the written field in that cycle.
- R11: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00. Without tick or write no register changes.
- R12: A write to address 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse that advances seconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select, 0 = seconds .. 6 = year |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds register |
| min_o | output | 8 | Minutes register |
| hour_o | output | 8 | Hours register with mode and PM bits |
| dow_o | output | 8 | Day-of-week register |
| date_o | output | 8 | Date register |
| month_o | output | 8 | Month register |
| year_o | output | 8 | Year register |

## Verification
The hardest conditions to reach are the deep carries, such as the year rolling over, or a February 28 in a leap year. From reset by ticking alone, these would take millions of ticks. The stimulus therefore preloads all seven registers through the write port to the second before each boundary and then applies one tick. The same-cycle collision between a write and a carry is built by placing the tick and the write on the same clock edge with the lower field at 0x59.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;

    localparam logic [BYTE_W-1:0] M_SEC   = 8'hFF;
    localparam logic [BYTE_W-1:0] M_MIN   = 8'h7F;
    localparam logic [BYTE_W-1:0] M_HOUR  = 8'h7F;
    localparam logic [BYTE_W-1:0] M_DOW   = 8'h07;
    localparam logic [BYTE_W-1:0] M_DATE  = 8'h3F;
    localparam logic [BYTE_W-1:0] M_MONTH = 8'h1F;
    localparam logic [BYTE_W-1:0] M_YEAR  = 8'hFF;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] year;
    } rtc_regs_t;
endpackage

// File: rtl/rtc_bcd_step.sv
// Increments a BCD value of W bits; returns first_i once last_i is reached.
module rtc_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] last_i,
    input  logic [W-1:0] first_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    logic [W-1:0] inc;

    generate
        if (W > 4) begin : g_two_digit
            localparam int TENS_W = W - 4;
            always_comb begin
                if (cur_i[3:0] == 4'h9) begin
                    inc = {cur_i[W-1:4] + TENS_W'(1), 4'h0};
                end else begin
                    inc = cur_i + W'(1);
                end
            end
        end else begin : g_one_digit
            assign inc = cur_i + W'(1);
        end
    endgenerate

    assign wrap_o = (cur_i == last_i);
    assign nxt_o  = wrap_o ? first_i : inc;
endmodule

// File: rtl/rtc_hour_step.sv
// Next hours value in either mode; day_o flags the roll into a new day.
module rtc_hour_step (
    input  logic [6:0] cur_i,
    output logic [6:0] nxt_o,
    output logic       day_o
);
    logic [5:0] h24_nxt;
    logic       h24_wrap;
    logic [4:0] h12_nxt;
    logic       pm_nxt;
    logic       at_eleven;

    rtc_bcd_step #(.W(6)) u_h24 (
        .cur_i  (cur_i[5:0]),
        .last_i (6'h23),
        .first_i(6'h00),
        .nxt_o  (h24_nxt),
        .wrap_o (h24_wrap)
    );

    always_comb begin
        at_eleven = (cur_i[4:0] == 5'h11);
        if (cur_i[4:0] == 5'h12) begin
            h12_nxt = 5'h01;
        end else if (cur_i[3:0] == 4'h9) begin
            h12_nxt = 5'h10;
        end else begin
            h12_nxt = cur_i[4:0] + 5'd1;
        end
        pm_nxt = cur_i[5] ^ at_eleven;

        if (cur_i[6]) begin
            nxt_o = {1'b1, pm_nxt, h12_nxt};
            day_o = cur_i[5] && at_eleven;
        end else begin
            nxt_o = {1'b0, h24_nxt};
            day_o = h24_wrap;
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
// Last BCD date of a month; leap test from the low year bits only.
module rtc_month_len (
    input  logic [4:0] month_i,
    input  logic       tens_lsb_i,
    input  logic [1:0] units_lo_i,
    output logic [5:0] last_o
);
    logic [1:0] leap_mod;
    logic       leap;

    always_comb begin
        leap_mod = units_lo_i + {tens_lsb_i, 1'b0};
        leap     = (leap_mod == 2'b00);
        case (month_i)
            5'h02:                      last_o = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            default:                    last_o = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] sec_o,
    output logic [BYTE_W-1:0] min_o,
    output logic [BYTE_W-1:0] hour_o,
    output logic [BYTE_W-1:0] dow_o,
    output logic [BYTE_W-1:0] date_o,
    output logic [BYTE_W-1:0] month_o,
    output logic [BYTE_W-1:0] year_o
);
    localparam rtc_regs_t RESET_REGS = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         dow: 8'h01, date: 8'h01, month: 8'h01,
                                         year: 8'h00};

    rtc_regs_t regs_d, regs_q;
    logic [NUM_FIELDS-1:0] wr_hit;

    logic [6:0] sec_nxt, min_nxt, hour_nxt;
    logic [2:0] dow_nxt;
    logic [5:0] date_nxt, date_last;
    logic [4:0] month_nxt;
    logic [7:0] year_nxt;
    logic sec_wrap, min_wrap, hour_day, dow_wrap, date_wrap, month_wrap, year_wrap;
    logic c_min_in, c_hour_in, c_day_in, c_month_in, c_year_in;

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_hit
            assign wr_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    endgenerate

    rtc_bcd_step #(.W(7)) u_sec (
        .cur_i(regs_q.sec[6:0]), .last_i(7'h59), .first_i(7'h00),
        .nxt_o(sec_nxt), .wrap_o(sec_wrap));

    rtc_bcd_step #(.W(7)) u_min (
        .cur_i(regs_q.min[6:0]), .last_i(7'h59), .first_i(7'h00),
        .nxt_o(min_nxt), .wrap_o(min_wrap));

    rtc_hour_step u_hour (
        .cur_i(regs_q.hour[6:0]), .nxt_o(hour_nxt), .day_o(hour_day));

    rtc_bcd_step #(.W(3)) u_dow (
        .cur_i(regs_q.dow[2:0]), .last_i(3'd7), .first_i(3'd1),
        .nxt_o(dow_nxt), .wrap_o(dow_wrap));

    rtc_month_len u_mlen (
        .month_i(regs_q.month[4:0]), .tens_lsb_i(regs_q.year[4]),
        .units_lo_i(regs_q.year[1:0]), .last_o(date_last));

    rtc_bcd_step #(.W(6)) u_date (
        .cur_i(regs_q.date[5:0]), .last_i(date_last), .first_i(6'h01),
        .nxt_o(date_nxt), .wrap_o(date_wrap));

    rtc_bcd_step #(.W(5)) u_month (
        .cur_i(regs_q.month[4:0]), .last_i(5'h12), .first_i(5'h01),
        .nxt_o(month_nxt), .wrap_o(month_wrap));

    rtc_bcd_step #(.W(8)) u_year (
        .cur_i(regs_q.year), .last_i(8'h99), .first_i(8'h00),
        .nxt_o(year_nxt), .wrap_o(year_wrap));

    always_comb begin
        c_min_in   = tick_1hz   && sec_wrap   && !wr_hit[A_SEC];
        c_hour_in  = c_min_in   && min_wrap   && !wr_hit[A_MIN];
        c_day_in   = c_hour_in  && hour_day   && !wr_hit[A_HOUR];
        c_month_in = c_day_in   && date_wrap  && !wr_hit[A_DATE];
        c_year_in  = c_month_in && month_wrap && !wr_hit[A_MONTH];

        regs_d = regs_q;
        if (tick_1hz)   regs_d.sec   = {regs_q.sec[7], sec_nxt};
        if (c_min_in)   regs_d.min   = {1'b0, min_nxt};
        if (c_hour_in)  regs_d.hour  = {1'b0, hour_nxt};
        if (c_day_in)   regs_d.dow   = {5'b0, dow_nxt};
        if (c_day_in)   regs_d.date  = {2'b0, date_nxt};
        if (c_month_in) regs_d.month = {3'b0, month_nxt};
        if (c_year_in)  regs_d.year  = year_nxt;

        if (wr_hit[A_SEC])   regs_d.sec   = wr_data & M_SEC;
        if (wr_hit[A_MIN])   regs_d.min   = wr_data & M_MIN;
        if (wr_hit[A_HOUR])  regs_d.hour  = wr_data & M_HOUR;
        if (wr_hit[A_DOW])   regs_d.dow   = wr_data & M_DOW;
        if (wr_hit[A_DATE])  regs_d.date  = wr_data & M_DATE;
        if (wr_hit[A_MONTH]) regs_d.month = wr_data & M_MONTH;
        if (wr_hit[A_YEAR])  regs_d.year  = wr_data & M_YEAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RESET_REGS;
        else        regs_q <= regs_d;
    end

    assign sec_o   = regs_q.sec;
    assign min_o   = regs_q.min;
    assign hour_o  = regs_q.hour;
    assign dow_o   = regs_q.dow;
    assign date_o  = regs_q.date;
    assign month_o = regs_q.month;
    assign year_o  = regs_q.year;

    // R1
    sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && sec_o[6:0] == 7'h59 && !(wr_en && wr_addr == A_SEC))
        |=> (sec_o[6:0] == 7'h00));

    // R2
    hour24_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hour_in && !wr_hit[A_HOUR] && hour_o == 8'h23) |=> (hour_o == 8'h00));

    // R3
    noon_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_hour_in && !wr_hit[A_HOUR] && hour_o == 8'h51) |=> (hour_o == 8'h72));

    // R4
    dow_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_day_in && dow_wrap && !wr_hit[A_DOW]) |=> (dow_o == 8'h01));

    // R7
    year_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_year_in && year_wrap && !wr_hit[A_YEAR]) |=> (year_o == 8'h00));

    // R9
    osc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_SEC) |=> $stable(sec_o[7]));

    // R10
    min_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MIN) |=> (min_o == ($past(wr_data) & M_MIN)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
            && $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o)));
endmodule

// File: tb/bcd_rtc_chain_tb.sv
`timescale 1ns/1ps
module bcd_rtc_chain_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_chain u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
        .year_o(year_o));

    // byte order: sec, min, hour, dow, date, month, year ; before tick | after tick
    localparam int NV = 23;
    localparam logic [111:0] VEC [NV] = '{
        {56'h58_00_00_01_01_01_00, 56'h59_00_00_01_01_01_00}, // R1
        {56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R1
        {56'h59_59_10_02_15_06_21, 56'h00_00_11_02_15_06_21}, // R1
        {56'h59_59_23_03_15_06_21, 56'h00_00_00_04_16_06_21}, // R2
        {56'h59_59_09_01_01_01_00, 56'h00_00_10_01_01_01_00}, // R2
        {56'h59_59_51_01_01_01_00, 56'h00_00_72_01_01_01_00}, // R3
        {56'h59_59_72_01_01_01_00, 56'h00_00_61_01_01_01_00}, // R3
        {56'h59_59_71_07_31_01_21, 56'h00_00_52_01_01_02_21}, // R3 R4
        {56'h59_59_52_01_01_01_00, 56'h00_00_41_01_01_01_00}, // R3
        {56'h59_59_49_01_01_01_00, 56'h00_00_50_01_01_01_00}, // R3
        {56'h59_59_23_02_30_04_21, 56'h00_00_00_03_01_05_21}, // R5
        {56'h59_59_23_02_29_06_21, 56'h00_00_00_03_30_06_21}, // R5
        {56'h59_59_23_01_31_08_21, 56'h00_00_00_02_01_09_21}, // R5
        {56'h59_59_23_01_30_09_21, 56'h00_00_00_02_01_10_21}, // R5
        {56'h59_59_23_01_28_02_21, 56'h00_00_00_02_01_03_21}, // R6
        {56'h59_59_23_01_28_02_24, 56'h00_00_00_02_29_02_24}, // R6
        {56'h59_59_23_01_29_02_00, 56'h00_00_00_02_01_03_00}, // R6
        {56'h59_59_23_01_28_02_96, 56'h00_00_00_02_29_02_96}, // R6
        {56'h59_59_23_01_28_02_98, 56'h00_00_00_02_01_03_98}, // R6
        {56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_01_00}, // R7
        {56'h59_59_23_01_31_12_41, 56'h00_00_00_02_01_01_42}, // R7
        {56'hD9_00_05_01_01_01_00, 56'h80_01_05_01_01_01_00}, // R9
        {56'h59_59_23_06_10_03_21, 56'h00_00_00_07_11_03_21}  // R4
    };
    localparam logic [3:0] VREQ [NV] = '{1,1,1,2,2,3,3,3,3,3,5,5,5,5,6,6,6,6,6,7,7,9,4};

    function automatic logic [55:0] regs();
        return {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    endfunction

    task automatic check(input logic [55:0] act, input logic [55:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic tk, input logic we, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_1hz = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
    endtask

    task automatic preload(input logic [55:0] v);
        for (int i = 0; i < 7; i++) cycle(1'b0, 1'b1, 3'(i), v[(6-i)*8 +: 8]);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [55:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        check(regs(), 56'h00_00_00_01_01_01_00, "R11 reset");
        repeat (5) @(negedge clk);
        check(regs(), 56'h00_00_00_01_01_01_00, "R11 idle");

        for (int v = 0; v < NV; v++) begin
            preload(VEC[v][111:56]);
            cycle(1'b1, 1'b0, 3'd0, 8'h00);
            check(regs(), VEC[v][55:0], $sformatf("R%0d vector %0d", VREQ[v], v));
        end

        // R8 masking of fixed-zero bits
        preload(56'h00_00_00_01_01_01_00);
        cycle(1'b0, 1'b1, 3'd1, 8'hB0);
        cycle(1'b0, 1'b1, 3'd2, 8'hA3);
        cycle(1'b0, 1'b1, 3'd3, 8'hF3);
        cycle(1'b0, 1'b1, 3'd4, 8'hC5);
        cycle(1'b0, 1'b1, 3'd5, 8'hE9);
        check(regs(), 56'h00_30_23_03_05_09_00, "R8 masks");

        // R12 address 7 is not a register
        snap = regs();
        cycle(1'b0, 1'b1, 3'd7, 8'hFF);
        check(regs(), snap, "R12 addr7");

        // R10 write to seconds during a wrapping tick: no minute carry
        preload(56'h59_10_05_01_01_01_00);
        cycle(1'b1, 1'b1, 3'd0, 8'h30);
        check(regs(), 56'h30_10_05_01_01_01_00, "R10 sec write");

        // R10 write to minutes while seconds carry into it
        preload(56'h59_44_05_01_01_01_00);
        cycle(1'b1, 1'b1, 3'd1, 8'h20);
        check(regs(), 56'h00_20_05_01_01_01_00, "R10 min write");

        // R10 written minutes do not carry into hours
        preload(56'h59_59_05_01_01_01_00);
        cycle(1'b1, 1'b1, 3'd1, 8'h59);
        check(regs(), 56'h00_59_05_01_01_01_00, "R10 carry cut");

        // R9 seconds flag written then counting keeps it
        preload(56'h00_00_05_01_01_01_00);
        cycle(1'b0, 1'b1, 3'd0, 8'h85);
        cycle(1'b1, 1'b0, 3'd0, 8'h00);
        check(regs(), 56'h86_00_05_01_01_01_00, "R9 flag kept");

        // R1 sixty ticks from 00:00 advance one minute
        preload(56'h00_00_00_01_01_01_00);
        for (int t = 0; t < 60; t++) cycle(1'b1, 1'b0, 3'd0, 8'h00);
        check(regs(), 56'h00_01_00_01_01_01_00, "R1 sixty ticks");

        // R11 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(regs(), 56'h00_00_00_01_01_01_00, "R11 re-reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule